// File: doc/BRIEF.md
# Thirty-Two Pin I/O Port Controller

This block is a general-purpose I/O port of up to 32 pins, controlled through a small 32-bit register bus. Software loads an output-value register and a direction register. Each of them can be written in three ways: as a whole, through a set alias that ORs a mask in, or through a clear alias that removes the masked bits. Each pin also has its own configuration word. That word holds the direction, the input-buffer connect control and the pull selection. The direction bit in the configuration word and the pin's bit in the port-wide direction register are one stored flop, so either register can be written and the other always matches.

On every clock the block resolves each pin's input level. It considers five things:
- whether the input buffer is connected,
- whether the pin drives itself as an output,
- what the outside world drives on the pin, given as an enable and a value,
- the pull setting,
- the level resolved on the previous cycle.

The result is registered and appears in the input register. The block also drives a per-pin output enable and output level toward the pads. It raises a short-circuit flag one cycle after any pin drives as an output while the outside also drives it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset these addresses read 0: output 0x000, output-set 0x004, output-clear 0x008, input 0x00C, direction 0x010, direction-set 0x014 and direction-clear 0x018. Every pin configuration word, at 0x100 + 4*pin, reads 0x00000002 (input, buffer disconnected).
- R2: A write to 0x014 sets the masked direction bits. A write to 0x018 clears them. A write to 0x010 loads the whole direction register. Reads of 0x014 and 0x018 return the direction register.
- R3: Bit 0 of a pin's configuration word always reads that pin's direction bit (1 = output), whichever register last changed it. Writing a configuration word loads that direction bit.
- R4: A write to 0x004 sets the masked output bits. A write to 0x008 clears them. A write to 0x000 loads the whole register. Reads of 0x004 and 0x008 return the output register.
- R5: `pin_drv_en` equals the direction register, and `pin_drv_val` equals output AND direction, one cycle after the write.
- R6: When configuration bit 1 is set (buffer disconnected), the pin's input bit reads 0 one cycle later.
- R7: For a connected input pin that the outside drives, the input bit equals the external value one cycle later.
- R8: For a connected, undriven input pin, pull code 3 in configuration bits 3:2 gives an input bit of 1 and pull code 1 gives 0, one cycle later.
- R9: For a connected, undriven input pin with pull code 0 or 2, the input bit keeps its previous value.
- R10: For a connected output pin, the input bit follows the pin's own output value one cycle later, even when the outside drives the opposite level.
- R11: `short_err` is 1 exactly one cycle after any pin is an output while its `ext_drv_en` is 1, and 0 otherwise.
- R12: Writes to the input address 0x00C, and to addresses that are not mapped, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address, used for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_drv_en | input | 32 | Per pin: 1 when the outside drives the pin |
| ext_drv_val | input | 32 | Per pin: the level the outside drives |
| pin_drv_en | output | 32 | Per pin: output enable toward the pad |
| pin_drv_val | output | 32 | Per pin: level driven toward the pad |
| short_err | output | 1 | Registered flag: an output pin is also driven from outside |

## Verification
The directed part walks a single pin through each resolution case in turn:
- disconnected,
- externally driven high and low,
- floating with pull-up and with pull-down,
- floating with no pull after a known level, which shows that the pin holds its previous value rather than returning to a default,
- self-driven as an output against an opposite external level, which shows the priority of self-drive over the outside and raises the short flag.

Masks with bits 0 and 31 set run through each direction alias, so every path from configuration to direction and back is covered at both ends of the port.

The random phase mixes whole, set and clear writes with configuration writes that include the reserved pull code, under random external drive. A bench model that steps through the same two clock edges checks the input, output, direction and flag values.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_OUT      = 12'h000;
  localparam logic [ADDR_W-1:0] A_OUT_SET  = 12'h004;
  localparam logic [ADDR_W-1:0] A_OUT_CLR  = 12'h008;
  localparam logic [ADDR_W-1:0] A_IN       = 12'h00C;
  localparam logic [ADDR_W-1:0] A_DIR      = 12'h010;
  localparam logic [ADDR_W-1:0] A_DIR_SET  = 12'h014;
  localparam logic [ADDR_W-1:0] A_DIR_CLR  = 12'h018;
  localparam logic [ADDR_W-1:0] A_CFG_BASE = 12'h100;

  typedef enum logic [1:0] {
    PULL_OFF  = 2'd0,
    PULL_LOW  = 2'd1,
    PULL_RSVD = 2'd2,
    PULL_HIGH = 2'd3
  } pull_e;

  typedef enum logic [1:0] {
    MOP_LOAD = 2'd0,
    MOP_SET  = 2'd1,
    MOP_CLR  = 2'd2
  } mask_op_e;

  // Whole-register update for load, set-alias and clear-alias writes
  function automatic logic [REG_W-1:0] mask_update(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] data,
                                                   input mask_op_e op);
    case (op)
      MOP_SET: return cur | data;
      MOP_CLR: return cur & ~data;
      default: return data;
    endcase
  endfunction

  // Input level of one pin, by priority
  function automatic logic resolve_level(input logic  is_out,
                                         input logic  out_val,
                                         input logic  disc,
                                         input pull_e pull,
                                         input logic  ext_en,
                                         input logic  ext_val,
                                         input logic  prev);
    if (disc)              return 1'b0;
    if (is_out)            return out_val;
    if (ext_en)            return ext_val;
    if (pull == PULL_HIGH) return 1'b1;
    if (pull == PULL_LOW)  return 1'b0;
    return prev;
  endfunction

  function automatic logic [REG_W-1:0] pack_cfg(input logic dir, input logic disc,
                                                input logic [1:0] pull);
    return {{(REG_W-4){1'b0}}, pull, disc, dir};
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wen,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [REG_W-1:0]      bus_wdata,
  input  logic [NPINS-1:0]      in_vec,
  output logic [REG_W-1:0]      bus_rdata,
  output logic [NPINS-1:0]      out_q,
  output logic [NPINS-1:0]      dir_q,
  output logic [NPINS-1:0]      disc_q,
  output logic [NPINS-1:0][1:0] pull_q
);
  localparam int unsigned IDX_W    = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int unsigned CFG_SPAN = NPINS * 4;

  logic [ADDR_W-1:0] cfg_off;
  logic              cfg_hit;
  logic [IDX_W-1:0]  cfg_idx;

  assign cfg_off = bus_addr - A_CFG_BASE;
  assign cfg_hit = (bus_addr >= A_CFG_BASE) && (cfg_off < ADDR_W'(CFG_SPAN)) &&
                   (bus_addr[1:0] == 2'b00);
  assign cfg_idx = cfg_off[IDX_W+1:2];

  // Named write events, one per target
  logic wr_out, wr_out_set, wr_out_clr, wr_dir, wr_dir_set, wr_dir_clr;
  logic wr_cfg, wr_dropped;
  assign wr_out     = bus_wen && (bus_addr == A_OUT);
  assign wr_out_set = bus_wen && (bus_addr == A_OUT_SET);
  assign wr_out_clr = bus_wen && (bus_addr == A_OUT_CLR);
  assign wr_dir     = bus_wen && (bus_addr == A_DIR);
  assign wr_dir_set = bus_wen && (bus_addr == A_DIR_SET);
  assign wr_dir_clr = bus_wen && (bus_addr == A_DIR_CLR);
  assign wr_cfg     = bus_wen && cfg_hit;
  assign wr_dropped = bus_wen && !(wr_out || wr_out_set || wr_out_clr ||
                                   wr_dir || wr_dir_set || wr_dir_clr || wr_cfg);

  mask_op_e out_op, dir_op;
  assign out_op = wr_out_set ? MOP_SET : (wr_out_clr ? MOP_CLR : MOP_LOAD);
  assign dir_op = wr_dir_set ? MOP_SET : (wr_dir_clr ? MOP_CLR : MOP_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      disc_q <= '1;
      pull_q <= '0;
    end else begin
      if (wr_out || wr_out_set || wr_out_clr)
        out_q <= NPINS'(mask_update(REG_W'(out_q), bus_wdata, out_op));
      if (wr_dir || wr_dir_set || wr_dir_clr)
        dir_q <= NPINS'(mask_update(REG_W'(dir_q), bus_wdata, dir_op));
      if (wr_cfg) begin
        dir_q[cfg_idx]  <= bus_wdata[0];
        disc_q[cfg_idx] <= bus_wdata[1];
        pull_q[cfg_idx] <= bus_wdata[3:2];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_OUT, A_OUT_SET, A_OUT_CLR: bus_rdata = REG_W'(out_q);
      A_IN:                        bus_rdata = REG_W'(in_vec);
      A_DIR, A_DIR_SET, A_DIR_CLR: bus_rdata = REG_W'(dir_q);
      default: if (cfg_hit) bus_rdata = pack_cfg(dir_q[cfg_idx], disc_q[cfg_idx], pull_q[cfg_idx]);
    endcase
  end

  AST_DIR_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_set |=> ((dir_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R2
  AST_DIR_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_clr |=> ((dir_q & $past(bus_wdata[NPINS-1:0])) == '0)); // R2
  AST_CFG_DIR_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (dir_q[$past(cfg_idx)] == $past(bus_wdata[0]))); // R3
  AST_OUT_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_set |=> ((out_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R4
  AST_OUT_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_clr |=> ((out_q & $past(bus_wdata[NPINS-1:0])) == '0)); // R4
  AST_DROPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |=> ($stable(out_q) && $stable(dir_q) && $stable(disc_q) && $stable(pull_q))); // R12
endmodule

// File: rtl/gpio_pin_cell.sv
`timescale 1ns/1ps
module gpio_pin_cell
  import gpio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_out,
  input  logic       out_val,
  input  logic       disc,
  input  logic [1:0] pull,
  input  logic       ext_en,
  input  logic       ext_val,
  output logic       level
);
  logic in_q;
  logic nxt_level;

  assign nxt_level = resolve_level(is_out, out_val, disc, pull_e'(pull), ext_en, ext_val, in_q);

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= 1'b0;
    else        in_q <= nxt_level;
  end
  assign level = in_q;

  // Named events per resolution case
  logic ev_floating, ev_no_pull;
  assign ev_floating = !disc && !is_out && !ext_en;
  assign ev_no_pull  = (pull == PULL_OFF) || (pull == PULL_RSVD);

  AST_DISC_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    disc |=> !level); // R6
  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!disc && !is_out && ext_en) |=> (level == $past(ext_val))); // R7
  AST_PULL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_floating && pull == PULL_HIGH) |=> level); // R8
  AST_PULL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_floating && pull == PULL_LOW) |=> !level); // R8
  AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_floating && ev_no_pull) |=> $stable(level)); // R9
  AST_SELF_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!disc && is_out) |=> (level == $past(out_val))); // R10
endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  ext_drv_en,
  input  logic [NPINS-1:0]  ext_drv_val,
  output logic [NPINS-1:0]  pin_drv_en,
  output logic [NPINS-1:0]  pin_drv_val,
  output logic              short_err
);
  logic [NPINS-1:0]      out_q, dir_q, disc_q, in_vec;
  logic [NPINS-1:0][1:0] pull_q;

  gpio_port_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .in_vec    (in_vec),
    .bus_rdata (bus_rdata),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .disc_q    (disc_q),
    .pull_q    (pull_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .is_out  (dir_q[p]),
      .out_val (out_q[p]),
      .disc    (disc_q[p]),
      .pull    (pull_q[p]),
      .ext_en  (ext_drv_en[p]),
      .ext_val (ext_drv_val[p]),
      .level   (in_vec[p])
    );
  end

  assign pin_drv_en  = dir_q;
  assign pin_drv_val = out_q & dir_q;

  logic [NPINS-1:0] clash_vec;
  logic             short_q;
  assign clash_vec = dir_q & ext_drv_en;

  always_ff @(posedge clk) begin
    if (!rst_n) short_q <= 1'b0;
    else        short_q <= |clash_vec;
  end
  assign short_err = short_q;

  AST_SHORT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pin_drv_en & ext_drv_en)) |=> short_err); // R11
  AST_SHORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_drv_en & ext_drv_en) == '0) |=> !short_err); // R11
  AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_drv_val & ~pin_drv_en) == '0)); // R5
endmodule

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ext_drv_en = '0, ext_drv_val = '0;
  logic [31:0] pin_drv_en, pin_drv_val;
  logic        short_err;

  always #2 clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_drv_en(ext_drv_en),
    .ext_drv_val(ext_drv_val), .pin_drv_en(pin_drv_en), .pin_drv_val(pin_drv_val),
    .short_err(short_err)
  );

  int  n_checks = 0, n_fail = 0;
  bit  finished = 1'b0;

  // bench model
  logic [31:0] m_out, m_dir, m_disc, m_in;
  logic [1:0]  m_pull [32];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [11:0] cfg_addr(input int p);
    return 12'h100 + 12'(p * 4);
  endfunction

  // Expected input level, restated from the requirements as a case table
  function automatic logic model_level(input logic disc, input logic dir, input logic o,
                                       input logic [1:0] pl, input logic en, input logic v,
                                       input logic prev);
    case ({disc, dir})
      2'b10, 2'b11: return 1'b0;
      2'b01:        return o;
      default: begin
        if (en) return v;
        case (pl)
          2'd3:    return 1'b1;
          2'd1:    return 1'b0;
          default: return prev;
        endcase
      end
    endcase
  endfunction

  task automatic model_step();
    for (int i = 0; i < 32; i++)
      m_in[i] = model_level(m_disc[i], m_dir[i], m_out[i], m_pull[i], ext_drv_en[i], ext_drv_val[i], m_in[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_out = '0; m_dir = '0; m_disc = '1; m_in = '0;
    for (int i = 0; i < 32; i++) m_pull[i] = 2'd0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    void'($urandom(32'h5eed_6a10));
    do_reset();
    @(negedge clk);

    // R1 reset values
    begin
      logic [11:0] zero_regs [7] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018};
      foreach (zero_regs[k]) begin
        bus_read(zero_regs[k], rd); check("R1 reset reg", rd, 32'h0);
      end
    end
    bus_read(cfg_addr(0), rd);  check("R1 reset cfg0", rd, 32'h2);
    bus_read(cfg_addr(31), rd); check("R1 reset cfg31", rd, 32'h2);

    // R2 / R3 direction views
    bus_write(12'h014, 32'h8000_0001);
    bus_read(12'h010, rd); check("R2 dirset", rd, 32'h8000_0001);
    bus_read(12'h018, rd); check("R2 dirclr alias read", rd, 32'h8000_0001);
    bus_read(cfg_addr(0), rd);  check("R3 cfg0 dir bit", rd & 32'h1, 32'h1);
    bus_read(cfg_addr(31), rd); check("R3 cfg31 dir bit", rd & 32'h1, 32'h1);
    bus_write(12'h018, 32'h8000_0001);
    bus_read(12'h010, rd); check("R2 dirclr", rd, 32'h0);
    bus_read(cfg_addr(31), rd); check("R3 cfg31 after clr", rd & 32'h1, 32'h0);
    bus_write(12'h010, 32'h8000_0001);
    bus_read(12'h014, rd); check("R2 dir load", rd, 32'h8000_0001);
    bus_read(cfg_addr(0), rd);  check("R3 cfg0 after load", rd & 32'h1, 32'h1);
    bus_write(12'h010, 32'h0);
    bus_write(cfg_addr(5), 32'h3);
    bus_read(12'h010, rd); check("R3 cfg write sets dir", rd, 32'h20);
    bus_write(cfg_addr(5), 32'h2);

    // R7 / R9 / R6 input path on pin 0
    bus_write(cfg_addr(0), 32'h0);
    @(negedge clk); ext_drv_en = 32'h1; ext_drv_val = 32'h0;
    settle(); bus_read(12'h00C, rd); check("R7 ext low", rd & 32'h1, 32'h0);
    ext_drv_val = 32'h1;
    settle(); bus_read(12'h00C, rd); check("R7 ext high", rd & 32'h1, 32'h1);
    ext_drv_en = 32'h0;
    settle(); bus_read(12'h00C, rd); check("R9 hold after release", rd & 32'h1, 32'h1);
    bus_write(cfg_addr(0), 32'h8);
    settle(); bus_read(12'h00C, rd); check("R9 reserved pull holds", rd & 32'h1, 32'h1);
    bus_write(cfg_addr(0), 32'h2);
    settle(); bus_read(12'h00C, rd); check("R6 disconnected", rd & 32'h1, 32'h0);

    // R8 pulls
    bus_write(cfg_addr(0), 32'hC);
    settle(); bus_read(12'h00C, rd); check("R8 pull up", rd & 32'h1, 32'h1);
    bus_write(cfg_addr(0), 32'h4);
    settle(); bus_read(12'h00C, rd); check("R8 pull down", rd & 32'h1, 32'h0);

    // R4 / R5 output
    bus_write(cfg_addr(0), 32'h3);
    bus_write(12'h004, 32'h1);
    bus_read(12'h000, rd); check("R4 outset", rd, 32'h1);
    bus_read(12'h008, rd); check("R4 outclr alias read", rd, 32'h1);
    check("R5 drive enable", pin_drv_en, 32'h1);
    check("R5 drive level", pin_drv_val, 32'h1);
    bus_write(12'h008, 32'h1);
    check("R5 drive level low", pin_drv_val, 32'h0);
    bus_write(12'h000, 32'h0000_0F00);
    check("R5 out without dir", pin_drv_val, 32'h0);
    bus_write(12'h000, 32'h0);

    // R10 / R11 self drive and short
    bus_write(cfg_addr(0), 32'h1);
    bus_write(12'h004, 32'h1);
    settle(); bus_read(12'h00C, rd); check("R10 self high", rd & 32'h1, 32'h1);
    bus_write(12'h008, 32'h1);
    @(negedge clk); ext_drv_en = 32'h1; ext_drv_val = 32'h1;
    settle(); bus_read(12'h00C, rd); check("R10 self beats ext", rd & 32'h1, 32'h0);
    check("R11 short raised", {31'd0, short_err}, 32'h1);
    ext_drv_en = 32'h0;
    settle(); check("R11 short cleared", {31'd0, short_err}, 32'h0);

    // R12 ignored writes
    bus_write(12'h004, 32'h0000_0005);
    bus_write(12'h00C, 32'hFFFF_FFFF);
    bus_write(12'h0FC, 32'hFFFF_FFFF);
    bus_write(12'h102, 32'hFFFF_FFFF);
    settle();
    bus_read(12'h000, rd); check("R12 out untouched", rd, 32'h5);
    bus_read(12'h010, rd); check("R12 dir untouched", rd, 32'h1);
    bus_read(12'h00C, rd); check("R12 in untouched", rd, 32'h1);
    bus_read(cfg_addr(0), rd); check("R12 cfg untouched", rd, 32'h1);

    // Random phase against the bench model
    do_reset();
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] d;
      @(negedge clk);
      ext_drv_en  = $urandom();
      ext_drv_val = $urandom();
      @(negedge clk);
      model_step();
      op = $urandom_range(0, 9);
      d  = $urandom();
      case (op)
        0: begin bus_write(12'h000, d); m_out = d; end
        1: begin bus_write(12'h004, d); m_out |= d; end
        2: begin bus_write(12'h008, d); m_out &= ~d; end
        3: begin bus_write(12'h010, d); m_dir = d; end
        4: begin bus_write(12'h014, d); m_dir |= d; end
        5: begin bus_write(12'h018, d); m_dir &= ~d; end
        9: bus_write(12'h00C, d);
        default: begin
          int p = $urandom_range(0, 31);
          bus_write(cfg_addr(p), d);
          m_dir[p] = d[0]; m_disc[p] = d[1]; m_pull[p] = d[3:2];
        end
      endcase
      @(negedge clk);
      model_step();
      bus_read(12'h00C, rd); check("R7 R8 R9 R10 random input", rd, m_in);
      bus_read(12'h000, rd); check("R4 R12 random out", rd, m_out);
      bus_read(12'h010, rd); check("R2 R3 random dir", rd, m_dir);
      check("R5 random drive", pin_drv_val, m_out & m_dir);
      check("R11 random short", {31'd0, short_err}, {31'd0, |(m_dir & ext_drv_en)});
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule